// File: doc/BRIEF.md
# Two-Ended Instruction Block Splitter

The splitter takes one half-instruction bundle, a row of fixed-width slots, and finds where each of its blocks starts and how many items each block holds. The number of blocks is odd. The blocks are located from both ends of the bundle at once. The low end of the bundle has a header slot, and so does the high end. Each end header gives the item count of the block next to it. The items inside a block sit at fixed positions, so the splitter only has to find each block's boundaries.

In the first stage the splitter resolves the block at the low end. Each later stage resolves two blocks: the next block from the low end and the next block from the high end. The middle block has no header. Its extent is the gap left between its two neighbours. If that gap comes out negative, the splitter raises an overlap flag.

Bundles enter through a valid/ready handshake, one per cycle at full rate. The pipeline has one register stage per resolution step. When the output is held, every stage is frozen.

Top module: `blk_split`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Slot i occupies `in_data[8*i +: 8]`. The count of block 0 is the low 3 bits of slot 0, and block 0 starts at slot 1.
- R3: The count of the last block is the low 3 bits of slot `in_len-1`. Its start is `in_len-1` minus that count. Starts and counts are 7-bit two's complement fields, and block k sits at bits `[7k+6:7k]`.
- R4: The middle block starts one slot past the end of block 0. Its count is the start of the last block minus its own start.
- R5: When that difference is negative, `out_err` is 1, the middle count reads 0, and the other fields are still reported.
- R6: A bundle accepted at one rising edge appears on the outputs after the second rising edge. This is one register per stage, with two stages for three blocks. `out_valid` stays 0 after the first edge.
- R7: Bundles are accepted back to back, one per cycle, and leave in order. None is lost or duplicated.
- R8: While `out_valid` is 1 and `out_ready` is 0, the outputs hold their values and `in_ready` is 0.
- R9: The header bits above the low 3 have no effect on any result.
- R10: Item slots, meaning every slot other than slot 0 and slot `in_len-1`, have no effect on any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A bundle is offered |
| in_ready | output | 1 | The splitter takes the offered bundle at this edge |
| in_data | input | 256 | 32 slots of 8 bits; slot 0 in the low byte |
| in_len | input | 7 | Bundle length in slots |
| out_valid | output | 1 | The result fields are valid |
| out_ready | input | 1 | The consumer takes the result |
| out_start | output | 21 | Start slot of each block, 7 bits per block |
| out_cnt | output | 21 | Item count of each block, 7 bits per block |
| out_err | output | 1 | The two end blocks overlap the middle |

## Verification
The bench builds the splitter with its default values: three blocks, 32 slots of 8 bits, and 3-bit header counts. With these values the end-block counts run through their full range of 0 to 7, and the middle block can grow to 30 items.

Most bundles are well formed, with random upper header bits and random item data. Some bundles are entirely random, which produces overlaps and negative tail starts. A few directed cases cover the smallest bundle, the largest bundle, and an exact overlap.

The ready signal on the output is toggled at random. This exercises the stall hold and the back-to-back acceptance.

// File: rtl/blksplit_pkg.sv
package blksplit_pkg;

    localparam int NUM_BLK  = 3;
    localparam int NUM_SLOT = 32;
    localparam int SLOT_W   = 8;
    localparam int CNT_W    = 3;

    localparam int HALF    = (NUM_BLK - 1) / 2;
    localparam int NUM_STG = HALF + 1;
    localparam int IDX_W   = $clog2(NUM_SLOT);
    localparam int POS_W   = IDX_W + 2;

    typedef logic signed [POS_W-1:0] pos_t;
    typedef logic [NUM_SLOT-1:0][SLOT_W-1:0] bundle_t;

    typedef struct packed {
        bundle_t                         data;
        pos_t                            len;
        logic [NUM_BLK-1:0][POS_W-1:0]   start;
        logic [NUM_BLK-1:0][POS_W-1:0]   cnt;
        logic [NUM_BLK-1:0]              done;
        logic                            err;
    } work_t;

    // Count field of the header slot at a given position; zero when outside the bundle.
    function automatic pos_t slot_count(input bundle_t b, input pos_t at);
        pos_t r;
        r = '0;
        if (at >= 0 && at < pos_t'(NUM_SLOT))
            r = pos_t'({{(POS_W-CNT_W){1'b0}}, b[at[IDX_W-1:0]][CNT_W-1:0]});
        return r;
    endfunction

endpackage

// File: rtl/blksplit_end_reader.sv
module blksplit_end_reader
    import blksplit_pkg::*;
#(
    parameter bit FROM_TAIL = 1'b0
) (
    input  bundle_t bundle,
    input  pos_t    hdr_pos,
    output pos_t    blk_start,
    output pos_t    blk_cnt
);

    // Low-end blocks sit just above their header; high-end blocks sit just below it.
    always_comb begin
        blk_cnt   = slot_count(bundle, hdr_pos);
        blk_start = FROM_TAIL ? (hdr_pos - blk_cnt) : (hdr_pos + pos_t'(1));
    end

endmodule

// File: rtl/blksplit_middle.sv
module blksplit_middle
    import blksplit_pkg::*;
(
    input  pos_t lo_end,
    input  pos_t hi_start,
    output pos_t mid_start,
    output pos_t mid_cnt,
    output logic overlap
);

    pos_t gap;

    always_comb begin
        gap       = hi_start - lo_end;
        overlap   = (gap < 0);
        mid_start = lo_end;
        mid_cnt   = overlap ? '0 : gap;
    end

endmodule

// File: rtl/blksplit_stage.sv
module blksplit_stage
    import blksplit_pkg::*;
#(
    parameter int STG = 0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  adv,
    input  logic  in_vld,
    input  work_t in_w,
    output logic  out_vld,
    output work_t out_w
);

    localparam bit HAS_HEAD = (STG < HALF);
    localparam bit HAS_TAIL = (STG >= 1);
    localparam bit HAS_MID  = (STG == HALF);
    localparam int TAIL_BLK = (STG == 0) ? NUM_BLK - 1 : NUM_BLK - STG;

    pos_t  h_start, h_cnt, t_start, t_cnt, m_start, m_cnt;
    logic  m_err;
    work_t nxt;

    generate
        if (HAS_HEAD) begin : g_head
            pos_t hdr;
            if (STG == 0) begin : g_origin
                assign hdr = '0;
            end else begin : g_follow
                assign hdr = pos_t'(in_w.start[STG-1]) + pos_t'(in_w.cnt[STG-1]);
            end
            blksplit_end_reader #(.FROM_TAIL(1'b0)) u_rd (
                .bundle(in_w.data), .hdr_pos(hdr), .blk_start(h_start), .blk_cnt(h_cnt)
            );
        end else begin : g_nohead
            assign h_start = '0;
            assign h_cnt   = '0;
        end

        if (HAS_TAIL) begin : g_tail
            pos_t hdr;
            if (STG == 1) begin : g_edge
                assign hdr = in_w.len - pos_t'(1);
            end else begin : g_inner
                assign hdr = pos_t'(in_w.start[TAIL_BLK+1]) - pos_t'(1);
            end
            blksplit_end_reader #(.FROM_TAIL(1'b1)) u_rd (
                .bundle(in_w.data), .hdr_pos(hdr), .blk_start(t_start), .blk_cnt(t_cnt)
            );
        end else begin : g_notail
            assign t_start = '0;
            assign t_cnt   = '0;
        end

        if (HAS_MID) begin : g_mid
            pos_t lo_end;
            assign lo_end = pos_t'(in_w.start[HALF-1]) + pos_t'(in_w.cnt[HALF-1]);
            blksplit_middle u_mid (
                .lo_end(lo_end), .hi_start(t_start),
                .mid_start(m_start), .mid_cnt(m_cnt), .overlap(m_err)
            );
        end else begin : g_nomid
            assign m_start = '0;
            assign m_cnt   = '0;
            assign m_err   = 1'b0;
        end
    endgenerate

    always_comb begin
        nxt = in_w;
        if (STG == 0) begin
            nxt.done = '0;
            nxt.err  = 1'b0;
        end
        if (HAS_HEAD) begin
            nxt.start[STG] = h_start;
            nxt.cnt[STG]   = h_cnt;
            nxt.done[STG]  = 1'b1;
        end
        if (HAS_TAIL) begin
            nxt.start[TAIL_BLK] = t_start;
            nxt.cnt[TAIL_BLK]   = t_cnt;
            nxt.done[TAIL_BLK]  = 1'b1;
        end
        if (HAS_MID) begin
            nxt.start[HALF] = m_start;
            nxt.cnt[HALF]   = m_cnt;
            nxt.done[HALF]  = 1'b1;
            nxt.err         = m_err;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
            out_w   <= '0;
        end else if (adv) begin
            out_vld <= in_vld;
            out_w   <= nxt;
        end
    end

    // R6: each stage has resolved one block more from each end than the last
    a_r6_progress: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> ($countones(out_w.done) == 2*STG + 1));

    generate
        if (STG == 1) begin : g_chk_edge
            // R3: last block ends just below the high-end header
            a_r3_tail_edge: assert property (@(posedge clk) disable iff (rst)
                out_vld |-> (pos_t'(out_w.start[NUM_BLK-1]) + pos_t'(out_w.cnt[NUM_BLK-1])
                             == out_w.len - pos_t'(1)));
        end
        if (HAS_MID) begin : g_chk_mid
            // R4: without overlap the middle block fills the gap exactly
            a_r4_mid_abut: assert property (@(posedge clk) disable iff (rst)
                (out_vld && !out_w.err) |-> (pos_t'(out_w.start[HALF]) + pos_t'(out_w.cnt[HALF])
                                             == pos_t'(out_w.start[HALF+1])));
            // R5: an overlap leaves the middle block empty
            a_r5_err_empty: assert property (@(posedge clk) disable iff (rst)
                (out_vld && out_w.err) |-> (out_w.cnt[HALF] == '0));
        end
    endgenerate

endmodule

// File: rtl/blk_split.sv
module blk_split
    import blksplit_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [NUM_SLOT*SLOT_W-1:0]  in_data,
    input  logic [POS_W-1:0]            in_len,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [NUM_BLK*POS_W-1:0]    out_start,
    output logic [NUM_BLK*POS_W-1:0]    out_cnt,
    output logic                        out_err
);

    localparam int LAST = NUM_STG - 1;

    work_t w_head;
    work_t w_q [NUM_STG];
    logic  v_q [NUM_STG];
    logic  adv;
    logic  unused_fields;

    always_comb begin
        w_head      = '0;
        w_head.data = in_data;
        w_head.len  = in_len;
    end

    // One enable for all stages: a held output freezes the whole pipe.
    assign adv      = !v_q[LAST] || out_ready;
    assign in_ready = adv;

    generate
        for (genvar s = 0; s < NUM_STG; s++) begin : g_stg
            if (s == 0) begin : g_first
                blksplit_stage #(.STG(0)) u_stage (
                    .clk(clk), .rst(rst), .adv(adv),
                    .in_vld(in_valid), .in_w(w_head),
                    .out_vld(v_q[0]), .out_w(w_q[0])
                );
            end else begin : g_rest
                blksplit_stage #(.STG(s)) u_stage (
                    .clk(clk), .rst(rst), .adv(adv),
                    .in_vld(v_q[s-1]), .in_w(w_q[s-1]),
                    .out_vld(v_q[s]), .out_w(w_q[s])
                );
            end
        end
    endgenerate

    assign out_valid = v_q[LAST];
    assign out_start = w_q[LAST].start;
    assign out_cnt   = w_q[LAST].cnt;
    assign out_err   = w_q[LAST].err;

    assign unused_fields = ^{w_q[LAST].data, w_q[LAST].len, w_q[LAST].done};

    // R8: a result that is not taken stays put
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_start)
                                       && $stable(out_cnt) && $stable(out_err)));

endmodule

// File: tb/blk_split_test.sv
module blk_split_test;
    import blksplit_pkg::*;

    localparam int DW = NUM_SLOT * SLOT_W;
    localparam int FW = NUM_BLK * POS_W;

    typedef struct packed {
        logic [FW-1:0] st;
        logic [FW-1:0] ct;
        logic          err;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid, in_ready, out_valid, out_ready, out_err;
    logic [DW-1:0] in_data;
    logic [POS_W-1:0] in_len;
    logic [FW-1:0] out_start, out_cnt;

    int   n_chk = 0;
    int   n_err = 0;
    exp_t q[$];
    bit   held = 1'b0;
    logic [FW-1:0] held_st, held_ct;
    logic [DW-1:0] cur_d;
    int   cur_len;
    bit   took;

    always #5 clk = ~clk;

    blk_split uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_len(in_len), .out_valid(out_valid),
        .out_ready(out_ready), .out_start(out_start), .out_cnt(out_cnt),
        .out_err(out_err)
    );

    // Expected values: three blocks, headers at slot 0 and slot len-1
    function automatic exp_t ref_split(input logic [DW-1:0] d, input int len);
        exp_t e;
        int c0, c2, s2, ms, diff;
        c0 = int'(d[CNT_W-1:0]);
        c2 = (len >= 1 && len <= NUM_SLOT) ? int'(d[(len-1)*SLOT_W +: CNT_W]) : 0;
        s2 = len - 1 - c2;
        ms = 1 + c0;
        diff = s2 - ms;
        e.err = (diff < 0);
        e.st  = {POS_W'(s2), POS_W'(ms), POS_W'(1)};
        e.ct  = {POS_W'(c2), POS_W'((diff < 0) ? 0 : diff), POS_W'(c0)};
        return e;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic make_bundle(input int c0, input int c1, input int c2,
                               output logic [DW-1:0] d, output int len);
        for (int i = 0; i < NUM_SLOT; i++) d[i*SLOT_W +: SLOT_W] = SLOT_W'($urandom);
        len = c0 + c1 + c2 + 2;
        d[0 +: SLOT_W] = {SLOT_W'($urandom) >> CNT_W, CNT_W'(c0)};
        d[(len-1)*SLOT_W +: SLOT_W] = {SLOT_W'($urandom) >> CNT_W, CNT_W'(c2)};
    endtask

    // One cycle: drive, then check what the coming edge will transfer.
    task automatic cycle(input bit v, input logic [DW-1:0] d, input int len,
                         input bit ordy, output bit accepted);
        exp_t e;
        @(negedge clk);
        in_valid = v; in_data = d; in_len = POS_W'(len); out_ready = ordy;
        #1;
        if (held) begin
            check(out_valid == 1'b1, "R8 valid held", 64'(out_valid), 64'd1);
            check(out_start == held_st && out_cnt == held_ct, "R8 fields held",
                  64'(out_start), 64'(held_st));
            held = 1'b0;
        end
        if (out_valid && out_ready) begin
            if (q.size() == 0) begin
                check(1'b0, "R7 unexpected result", 64'd1, 64'd0);
            end else begin
                e = q.pop_front();
                check(out_start[0 +: POS_W] == e.st[0 +: POS_W] && out_cnt[0 +: POS_W] == e.ct[0 +: POS_W],
                      "R2/R9/R10 block0", 64'({out_start[0 +: POS_W], out_cnt[0 +: POS_W]}),
                      64'({e.st[0 +: POS_W], e.ct[0 +: POS_W]}));
                check(out_start[2*POS_W +: POS_W] == e.st[2*POS_W +: POS_W]
                      && out_cnt[2*POS_W +: POS_W] == e.ct[2*POS_W +: POS_W],
                      "R3/R9/R10 last block", 64'({out_start[2*POS_W +: POS_W], out_cnt[2*POS_W +: POS_W]}),
                      64'({e.st[2*POS_W +: POS_W], e.ct[2*POS_W +: POS_W]}));
                check(out_start[POS_W +: POS_W] == e.st[POS_W +: POS_W]
                      && out_cnt[POS_W +: POS_W] == e.ct[POS_W +: POS_W],
                      "R4 middle block", 64'({out_start[POS_W +: POS_W], out_cnt[POS_W +: POS_W]}),
                      64'({e.st[POS_W +: POS_W], e.ct[POS_W +: POS_W]}));
                check(out_err == e.err, "R5 overlap flag", 64'(out_err), 64'(e.err));
            end
        end
        if (out_valid && !out_ready) begin
            check(in_ready == 1'b0, "R8 no intake while held", 64'(in_ready), 64'd0);
            held = 1'b1; held_st = out_start; held_ct = out_cnt;
        end
        accepted = v && in_ready;
        if (accepted) q.push_back(ref_split(d, len));
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [DW-1:0] d;
        int len;
        void'($urandom(32'h5EED));
        rst = 1'b1; in_valid = 1'b0; in_data = '0; in_len = '0; out_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R1: reset state
        check(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'd0);
        check(in_ready == 1'b1, "R1 in_ready", 64'(in_ready), 64'd1);

        // R6: latency, smallest bundle
        make_bundle(0, 0, 0, d, len);
        cycle(1'b1, d, len, 1'b1, took);
        cycle(1'b0, d, len, 1'b1, took);
        check(out_valid == 1'b0, "R6 not after one edge", 64'(out_valid), 64'd0);
        cycle(1'b0, d, len, 1'b1, took);
        check(out_valid == 1'b1, "R6 valid after two edges", 64'(out_valid), 64'd1);

        // Directed: largest well-formed bundle
        make_bundle(7, NUM_SLOT - 16, 7, d, len);
        cycle(1'b1, d, len, 1'b1, took);
        // Directed: end blocks overlap (R5)
        d = '0; d[0 +: SLOT_W] = 8'hFB; d[3*SLOT_W +: SLOT_W] = 8'h03; len = 4;
        cycle(1'b1, d, len, 1'b1, took);
        // Directed R10: same headers, different item data
        make_bundle(2, 5, 4, d, len);
        cycle(1'b1, d, len, 1'b1, took);
        for (int i = 1; i < len - 1; i++) d[i*SLOT_W +: SLOT_W] = ~d[i*SLOT_W +: SLOT_W];
        cycle(1'b1, d, len, 1'b1, took);

        // Random traffic with random back-pressure (R7, R8)
        begin
            bit have = 1'b0;
            for (int n = 0; n < 4000; n++) begin
                if (!have) begin
                    if ($urandom % 8 == 0) begin
                        for (int i = 0; i < NUM_SLOT; i++) cur_d[i*SLOT_W +: SLOT_W] = SLOT_W'($urandom);
                        cur_len = 1 + int'($urandom % NUM_SLOT);
                    end else begin
                        int c0, c1, c2;
                        c0 = int'($urandom % 8);
                        c2 = int'($urandom % 8);
                        c1 = int'($urandom % (NUM_SLOT - 2 - c0 - c2 + 1));
                        make_bundle(c0, c1, c2, cur_d, cur_len);
                    end
                    have = ($urandom % 5 != 0);
                end
                cycle(have, cur_d, cur_len, ($urandom % 4 != 0), took);
                if (took) have = 1'b0;
            end
        end

        // Drain and confirm nothing was lost (R7)
        for (int n = 0; n < 8; n++) cycle(1'b0, '0, 0, 1'b1, took);
        check(q.size() == 0, "R7 all results delivered", 64'(q.size()), 64'd0);
        finish_run();
    end

endmodule